// File: doc/BRIEF.md
# PHY Management Register Bank

This block is the slave-side register bank that a network PHY presents to its management port. A management serializer (not part of this block) hands it parallel register accesses: a 5-bit register number, 16-bit write data, a write strobe and a read strobe. The bank answers with 16-bit read data one cycle after each read strobe. It holds the basic control word, the basic status word, the gigabit extended status word and the two identifier halves. Any other register number reads as zero and ignores writes.

The control word drives the PHY core directly. It provides loopback, power down, isolate, negotiation enable, a one-cycle negotiation restart strobe and a collision test pulse. A soft reset runs for a fixed number of cycles, and control writes are refused while it runs. The bank also resolves the effective line speed and duplex. They come from the forced control bits when negotiation is off, and from the negotiation result inputs when it is on. It decides whether transmit is enabled, taking the forced-mode unidirectional option into account.

The status word combines fixed capability bits with live inputs from the core. Link state is held low once it drops. Jabber and remote fault are held high once seen. All three held values are released by a read of the status word.

Top module: `mgmt_regbank`

## Requirements
- R1: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. Register 2 returns `PHY_ID[31:16]`, register 3 returns `PHY_ID[15:0]`, and register 15 returns `{GIG_ABILITY, 12'h000}`. Every other number except 0 and 1 returns 0. Writes to any register other than 0 have no effect.
- R2: Writing register 0 with bit 15 set starts a soft reset. `reset_busy` is 1 for exactly `RESET_CYCLES` cycles, and bit 15 reads 1 during that time. The other control fields return to the default word 16'h1000 (negotiation on, all else 0), and the held status bits are released.
- R3: While `reset_busy` is 1, every write to register 0 is discarded.
- R4: With control bit 12 at 0, `eff_speed` follows {bit 6, bit 13}: 00 means 10 Mb/s, 01 means 100 Mb/s and 10 means 1000 Mb/s. The reserved code 11 yields 00. `eff_full_duplex` follows bit 8.
- R5: With control bit 12 at 1, `eff_speed` equals `an_speed` and `eff_full_duplex` equals `an_full_duplex`, whatever the forced bits hold.
- R6: A write that sets both bit 9 and bit 12 raises `an_restart` for the single cycle after the write. Bit 9 reads 0 afterwards. With bit 12 at 0, bit 9 produces no strobe.
- R7: Writing bit 7 as 1 raises `col_test` for exactly `COL_PULSE_CYCLES` cycles. Bit 7 reads 1 during the pulse and 0 after it.
- R8: Control bits 14, 11 and 10 drive `loopback_en`, `power_down` and `isolate`. Bit 12 drives `an_enable`. Bits 14, 13, 12, 11, 10, 8, 6 and 5 read back as written.
- R9: `tx_enable` is 1 when `link_up` is 1. It is also 1 when bit 12 is 0, bit 8 is 1 and bit 5 is 1. In every other case it is 0, so bit 5 has no effect when bit 12 is 1 or bit 8 is 0.
- R10: Control bits 4:0 ignore writes and always read 0.
- R11: The status word is {`ABILITY`[6:0] in bits 15:9, 1 in bit 8, 1 in bit 7, 0 in bit 6, `an_done` in bit 5, held remote fault in bit 4, 1 in bit 3, held link in bit 2, held jabber in bit 1, 1 in bit 0}.
- R12: Status bit 2 reads 0 if `link_up` has been 0 at any time since the previous status read. Otherwise it reads the live `link_up`.
- R13: Status bits 1 and 4 read 1 if `jabber_det` or `remote_fault` respectively has been 1 at any time since the previous status read. Otherwise they read the live input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register number |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| link_up | input | 1 | Live link state from the core |
| jabber_det | input | 1 | Jabber condition from the core |
| remote_fault | input | 1 | Remote fault from the core |
| an_done | input | 1 | Negotiation complete |
| an_speed | input | 2 | Negotiated speed code |
| an_full_duplex | input | 1 | Negotiated duplex |
| reset_busy | output | 1 | Soft reset in progress |
| loopback_en | output | 1 | Loopback enable |
| power_down | output | 1 | Power down request |
| isolate | output | 1 | Isolate request |
| an_enable | output | 1 | Negotiation enabled |
| an_restart | output | 1 | One-cycle negotiation restart strobe |
| col_test | output | 1 | Collision test pulse |
| eff_speed | output | 2 | Effective speed code |
| eff_full_duplex | output | 1 | Effective duplex |
| tx_enable | output | 1 | Transmit permitted |

## Verification
Control fields, `loopback_en`, `power_down`, `isolate`, `an_enable` and the derived speed, duplex and transmit outputs change at the clock edge that samples the write. The bench therefore checks them at the falling edge that follows that write edge. `an_restart` is high during exactly that first cycle, while `col_test` and `reset_busy` start there and last their parameter lengths. A monitor counts their high cycles at falling edges, and the totals are compared with the parameters. Read data and the release of held status bits both take effect at the edge that samples `reg_rd`, so each read is checked at the next falling edge, and a second read confirms the release.

// File: rtl/mgmt_regbank_pkg.sv
package mgmt_regbank_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'd1;
  localparam logic [ADDR_W-1:0] A_IDHI  = 5'd2;
  localparam logic [ADDR_W-1:0] A_IDLO  = 5'd3;
  localparam logic [ADDR_W-1:0] A_XSTAT = 5'd15;

  localparam logic [DATA_W-1:0] CTRL_DEFAULT = 16'h1000;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  typedef struct packed {
    logic loopback;
    logic spd_lsb;
    logic an_en;
    logic power_down;
    logic isolate;
    logic duplex;
    logic spd_msb;
    logic unidir;
  } ctrl_fields_t;

  function automatic ctrl_fields_t unpack_ctrl(logic [DATA_W-1:0] w);
    ctrl_fields_t f;
    f.loopback   = w[14];
    f.spd_lsb    = w[13];
    f.an_en      = w[12];
    f.power_down = w[11];
    f.isolate    = w[10];
    f.duplex     = w[8];
    f.spd_msb    = w[6];
    f.unidir     = w[5];
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(logic busy, ctrl_fields_t f,
                                                  logic restart, logic col);
    return {busy, f.loopback, f.spd_lsb, f.an_en, f.power_down, f.isolate,
            restart, f.duplex, col, f.spd_msb, f.unidir, 5'b00000};
  endfunction

  function automatic speed_e forced_speed(logic msb, logic lsb);
    logic [1:0] code;
    code = {msb, lsb};
    if (code == SPD_RSVD) return SPD_10;
    return speed_e'(code);
  endfunction

  function automatic logic unidir_active(logic an_en, logic duplex, logic unidir);
    return !an_en && duplex && unidir;
  endfunction

  function automatic logic [DATA_W-1:0] status_word(logic [6:0] abil, logic an_cmp,
                                                    logic rfault, logic link,
                                                    logic jab);
    return {abil, 1'b1, 1'b1, 1'b0, an_cmp, rfault, 1'b1, link, jab, 1'b1};
  endfunction

endpackage

// File: rtl/mgmt_pulse_timer.sv
module mgmt_pulse_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  output logic active
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear)                 cnt <= '0;
    else if (start && cnt == '0)    cnt <= CW'(LEN);
    else if (cnt != '0)             cnt <= cnt - CW'(1);
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/mgmt_ctrl_reg.sv
module mgmt_ctrl_reg
  import mgmt_regbank_pkg::*;
#(
  parameter int unsigned RESET_CYCLES     = 16,
  parameter int unsigned COL_PULSE_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic [DATA_W-1:0]   wdata,
  output ctrl_fields_t        fields,
  output logic                busy,
  output logic                restart,
  output logic                col_active,
  output logic                reset_start,
  output logic                wr_accept,
  output logic                wr_blocked,
  output logic [DATA_W-1:0]   ctrl_image
);
  ctrl_fields_t wfields;

  assign wfields     = unpack_ctrl(wdata);
  assign wr_blocked  = wr_ctrl && busy;
  assign reset_start = wr_ctrl && !busy && wdata[15];
  assign wr_accept   = wr_ctrl && !busy && !wdata[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fields <= unpack_ctrl(CTRL_DEFAULT);
    else if (reset_start) fields <= unpack_ctrl(CTRL_DEFAULT);
    else if (wr_accept)   fields <= wfields;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart <= 1'b0;
    else        restart <= wr_accept && wfields.an_en && wdata[9];
  end

  mgmt_pulse_timer #(.LEN(RESET_CYCLES)) u_reset_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (1'b0),
    .start  (reset_start),
    .active (busy)
  );

  mgmt_pulse_timer #(.LEN(COL_PULSE_CYCLES)) u_col_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (reset_start),
    .start  (wr_accept && wdata[7]),
    .active (col_active)
  );

  assign ctrl_image = pack_ctrl(busy, fields, restart, col_active);
endmodule

// File: rtl/mgmt_status_latch.sv
module mgmt_status_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic rd_stat,
  input  logic link_up,
  input  logic jabber,
  input  logic rfault,
  output logic link_view,
  output logic jabber_view,
  output logic rfault_view
);
  localparam int unsigned N_HI = 2;

  logic            link_dropped;
  logic [N_HI-1:0] hi_in;
  logic [N_HI-1:0] hi_held;

  assign hi_in = {rfault, jabber};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              link_dropped <= 1'b0;
    else if (clear || rd_stat) link_dropped <= 1'b0;
    else if (!link_up)       link_dropped <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_held <= '0;
    else if (clear || rd_stat) hi_held <= '0;
    else                       hi_held <= hi_held | hi_in;
  end

  assign link_view   = link_up && !link_dropped;
  assign jabber_view = hi_held[0] | hi_in[0];
  assign rfault_view = hi_held[1] | hi_in[1];
endmodule

// File: rtl/mgmt_mode_resolve.sv
module mgmt_mode_resolve
  import mgmt_regbank_pkg::*;
(
  input  ctrl_fields_t fields,
  input  logic [1:0]   an_speed,
  input  logic         an_full_duplex,
  input  logic         link_up,
  output logic [1:0]   eff_speed,
  output logic         eff_full_duplex,
  output logic         tx_enable
);
  speed_e spd;

  always_comb begin
    if (fields.an_en) spd = speed_e'(an_speed);
    else              spd = forced_speed(fields.spd_msb, fields.spd_lsb);
  end

  assign eff_speed       = spd;
  assign eff_full_duplex = fields.an_en ? an_full_duplex : fields.duplex;
  assign tx_enable       = link_up ||
                           unidir_active(fields.an_en, fields.duplex, fields.unidir);
endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
  import mgmt_regbank_pkg::*;
#(
  parameter int unsigned RESET_CYCLES     = 16,
  parameter int unsigned COL_PULSE_CYCLES = 4,
  parameter logic [31:0] PHY_ID           = 32'h3C5A_91E7,
  parameter logic [6:0]  ABILITY          = 7'b0111100,
  parameter logic [3:0]  GIG_ABILITY      = 4'b0011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic        reg_wr,
  input  logic        reg_rd,
  output logic [15:0] reg_rdata,
  input  logic        link_up,
  input  logic        jabber_det,
  input  logic        remote_fault,
  input  logic        an_done,
  input  logic [1:0]  an_speed,
  input  logic        an_full_duplex,
  output logic        reset_busy,
  output logic        loopback_en,
  output logic        power_down,
  output logic        isolate,
  output logic        an_enable,
  output logic        an_restart,
  output logic        col_test,
  output logic [1:0]  eff_speed,
  output logic        eff_full_duplex,
  output logic        tx_enable
);
  ctrl_fields_t       fields;
  logic [DATA_W-1:0]  ctrl_image;
  logic [DATA_W-1:0]  stat_image;
  logic [DATA_W-1:0]  rd_mux;
  logic               link_view, jabber_view, rfault_view;

  // named internal events
  logic ctrl_wr_accept;
  logic ctrl_wr_blocked;
  logic soft_reset_start;
  logic stat_read;

  assign stat_read = reg_rd && (reg_addr == A_STAT);

  mgmt_ctrl_reg #(
    .RESET_CYCLES     (RESET_CYCLES),
    .COL_PULSE_CYCLES (COL_PULSE_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (reg_wr && (reg_addr == A_CTRL)),
    .wdata       (reg_wdata),
    .fields      (fields),
    .busy        (reset_busy),
    .restart     (an_restart),
    .col_active  (col_test),
    .reset_start (soft_reset_start),
    .wr_accept   (ctrl_wr_accept),
    .wr_blocked  (ctrl_wr_blocked),
    .ctrl_image  (ctrl_image)
  );

  mgmt_status_latch u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (soft_reset_start),
    .rd_stat     (stat_read),
    .link_up     (link_up),
    .jabber      (jabber_det),
    .rfault      (remote_fault),
    .link_view   (link_view),
    .jabber_view (jabber_view),
    .rfault_view (rfault_view)
  );

  mgmt_mode_resolve u_mode (
    .fields          (fields),
    .an_speed        (an_speed),
    .an_full_duplex  (an_full_duplex),
    .link_up         (link_up),
    .eff_speed       (eff_speed),
    .eff_full_duplex (eff_full_duplex),
    .tx_enable       (tx_enable)
  );

  assign stat_image = status_word(ABILITY, an_done, rfault_view, link_view, jabber_view);

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_mux = ctrl_image;
      A_STAT:  rd_mux = stat_image;
      A_IDHI:  rd_mux = PHY_ID[31:16];
      A_IDLO:  rd_mux = PHY_ID[15:0];
      A_XSTAT: rd_mux = {GIG_ABILITY, 12'h000};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign loopback_en = fields.loopback;
  assign power_down  = fields.power_down;
  assign isolate     = fields.isolate;
  assign an_enable   = fields.an_en;
endmodule

// File: rtl/mgmt_regbank_chk.sv
module mgmt_regbank_chk #(
  parameter int unsigned RESET_CYCLES     = 16,
  parameter int unsigned COL_PULSE_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic        reg_rd,
  input logic [15:0] reg_rdata,
  input logic        link_up,
  input logic        jabber_det,
  input logic        reset_busy,
  input logic        loopback_en,
  input logic        power_down,
  input logic        isolate,
  input logic        an_enable,
  input logic        an_restart,
  input logic        col_test,
  input logic        eff_full_duplex,
  input logic        tx_enable,
  input logic        ctrl_wr_accept,
  input logic        ctrl_wr_blocked,
  input logic        soft_reset_start,
  input logic        stat_read
);
  logic        past_valid;
  int unsigned busy_run;
  int unsigned col_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_valid <= 1'b0;
      busy_run   <= 0;
      col_run    <= 0;
    end else begin
      past_valid <= 1'b1;
      busy_run   <= reset_busy ? busy_run + 1 : 0;
      col_run    <= col_test ? col_run + 1 : 0;
    end
  end

  a_r2_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_busy) |-> $past(soft_reset_start));

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $fell(reset_busy)) |-> busy_run == RESET_CYCLES);

  a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= RESET_CYCLES);

  a_r3_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_blocked |=> $stable({loopback_en, power_down, isolate, an_enable}));

  a_r6_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> !an_restart);

  a_r6_restart_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && an_restart) |-> ($past(ctrl_wr_accept) && an_enable));

  a_r7_col_length: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $fell(col_test)) |-> col_run == COL_PULSE_CYCLES);

  a_r9_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && (an_enable || !eff_full_duplex)) |-> !tx_enable);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(reg_rd && reg_addr == 5'd0)) |-> reg_rdata[4:0] == 5'd0);

  a_r12_link_low: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && !link_up) |=> !reg_rdata[2]);

  a_r13_jabber_high: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && jabber_det) |=> reg_rdata[1]);
endmodule

bind mgmt_regbank mgmt_regbank_chk #(
  .RESET_CYCLES     (RESET_CYCLES),
  .COL_PULSE_CYCLES (COL_PULSE_CYCLES)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .reg_addr         (reg_addr),
  .reg_rd           (reg_rd),
  .reg_rdata        (reg_rdata),
  .link_up          (link_up),
  .jabber_det       (jabber_det),
  .reset_busy       (reset_busy),
  .loopback_en      (loopback_en),
  .power_down       (power_down),
  .isolate          (isolate),
  .an_enable        (an_enable),
  .an_restart       (an_restart),
  .col_test         (col_test),
  .eff_full_duplex  (eff_full_duplex),
  .tx_enable        (tx_enable),
  .ctrl_wr_accept   (ctrl_wr_accept),
  .ctrl_wr_blocked  (ctrl_wr_blocked),
  .soft_reset_start (soft_reset_start),
  .stat_read        (stat_read)
);

// File: tb/mgmt_regbank_test.sv
`timescale 1ns/1ps
module mgmt_regbank_test;
  localparam int unsigned RST  = 20;
  localparam int unsigned COL  = 3;
  localparam logic [31:0] ID   = 32'h71E4_0B29;
  localparam logic [6:0]  ABIL = 7'b0111100;
  localparam logic [3:0]  GIG  = 4'b0011;
  localparam logic [15:0] RB_MASK = 16'h7D60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        link_up = 1'b1, jabber_det = 1'b0, remote_fault = 1'b0, an_done = 1'b1;
  logic [1:0]  an_speed = 2'b00;
  logic        an_full_duplex = 1'b0;
  logic        reset_busy, loopback_en, power_down, isolate, an_enable, an_restart;
  logic        col_test, eff_full_duplex, tx_enable;
  logic [1:0]  eff_speed;

  int n_cmp = 0, n_bad = 0;
  int busy_seen = 0, col_seen = 0, restart_seen = 0;
  bit done = 1'b0;
  logic [15:0] d;

  mgmt_regbank #(
    .RESET_CYCLES(RST), .COL_PULSE_CYCLES(COL), .PHY_ID(ID),
    .ABILITY(ABIL), .GIG_ABILITY(GIG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .link_up(link_up), .jabber_det(jabber_det), .remote_fault(remote_fault),
    .an_done(an_done), .an_speed(an_speed), .an_full_duplex(an_full_duplex),
    .reset_busy(reset_busy), .loopback_en(loopback_en), .power_down(power_down),
    .isolate(isolate), .an_enable(an_enable), .an_restart(an_restart),
    .col_test(col_test), .eff_speed(eff_speed), .eff_full_duplex(eff_full_duplex),
    .tx_enable(tx_enable)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (reset_busy) busy_seen++;
    if (col_test)   col_seen++;
    if (an_restart) restart_seen++;
  end

  typedef struct packed {
    logic [15:0] ctrl;
    logic        link;
    logic [1:0]  aspd;
    logic        afd;
    logic [1:0]  espd;
    logic        efd;
    logic        etx;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{16'h0000, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0},  // R4 10M half
    '{16'h2000, 1'b1, 2'b10, 1'b1, 2'b01, 1'b0, 1'b1},  // R4 100M half
    '{16'h0140, 1'b0, 2'b00, 1'b0, 2'b10, 1'b1, 1'b0},  // R4 1000M full
    '{16'h0160, 1'b0, 2'b00, 1'b0, 2'b10, 1'b1, 1'b1},  // R9 unidir forced full
    '{16'h2040, 1'b1, 2'b10, 1'b1, 2'b00, 1'b0, 1'b1},  // R4 reserved code
    '{16'h0020, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0},  // R9 unidir ignored, half
    '{16'h1120, 1'b0, 2'b10, 1'b0, 2'b10, 1'b0, 1'b0},  // R5 R9 negotiated
    '{16'h3140, 1'b1, 2'b01, 1'b1, 2'b01, 1'b1, 1'b1},  // R5 forced bits ignored
    '{16'h4000, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0},  // R8 loopback
    '{16'h0C00, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1},  // R8 power down, isolate
    '{16'h001F, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0}   // R10 reserved bits
  };

  function automatic logic [15:0] exp_status(logic an_c, logic rf, logic lk, logic jb);
    logic [15:0] s;
    s = '0;
    s[15:9] = ABIL; s[8] = 1'b1; s[7] = 1'b1; s[6] = 1'b0;
    s[5] = an_c; s[4] = rf; s[3] = 1'b1; s[2] = lk; s[1] = jb; s[0] = 1'b1;
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(5'd0, d);
    chk("R2 default control", d, 16'h1000);
    chk("R2 idle outputs", {reset_busy, col_test, an_restart, an_enable}, 4'b0001);

    // R1 map and read-only space
    rd(5'd2, d);  chk("R1 id high", d, ID[31:16]);
    rd(5'd3, d);  chk("R1 id low", d, ID[15:0]);
    rd(5'd15, d); chk("R1 extended status", d, {GIG, 12'h000});
    rd(5'd9, d);  chk("R1 unimplemented 9", d, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R1 read data held", reg_rdata, 16'h0000);
    rd(5'd31, d); chk("R1 unimplemented 31", d, 16'h0000);
    wr(5'd2, 16'h0000);
    wr(5'd1, 16'h0000);
    wr(5'd15, 16'hFFFF);
    rd(5'd2, d);  chk("R1 id write ignored", d, ID[31:16]);
    rd(5'd15, d); chk("R1 xstat write ignored", d, {GIG, 12'h000});

    // R11 status layout
    rd(5'd1, d);  chk("R11 status word", d, exp_status(1'b1, 1'b0, 1'b1, 1'b0));
    an_done = 1'b0;
    rd(5'd1, d);  chk("R11 live negotiation done", d, exp_status(1'b0, 1'b0, 1'b1, 1'b0));
    an_done = 1'b1;

    // table walk: forced / negotiated mode, outputs, readback
    for (int i = 0; i < NV; i++) begin
      link_up = VEC[i].link; an_speed = VEC[i].aspd; an_full_duplex = VEC[i].afd;
      wr(5'd0, VEC[i].ctrl);
      chk($sformatf("R4_R5 speed vec%0d", i), eff_speed, VEC[i].espd);
      chk($sformatf("R4_R5 duplex vec%0d", i), eff_full_duplex, VEC[i].efd);
      chk($sformatf("R9 tx_enable vec%0d", i), tx_enable, VEC[i].etx);
      chk($sformatf("R8 outputs vec%0d", i), {loopback_en, power_down, isolate, an_enable},
          {VEC[i].ctrl[14], VEC[i].ctrl[11], VEC[i].ctrl[10], VEC[i].ctrl[12]});
      rd(5'd0, d);
      chk($sformatf("R8_R10 readback vec%0d", i), d, VEC[i].ctrl & RB_MASK);
    end
    link_up = 1'b1;

    // R6 restart strobe
    restart_seen = 0;
    @(negedge clk);
    reg_addr = 5'd0; reg_wdata = 16'h1200; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R6 restart pulse", an_restart, 1'b1);
    @(negedge clk);
    chk("R6 restart cleared", an_restart, 1'b0);
    rd(5'd0, d);  chk("R6 bit9 reads 0", d, 16'h1000);
    chk("R6 one pulse", restart_seen, 1);
    wr(5'd0, 16'h0200);
    repeat (3) @(negedge clk);
    chk("R6 no pulse without negotiation", restart_seen, 1);

    // R7 collision test
    col_seen = 0;
    wr(5'd0, 16'h0080);
    rd(5'd0, d);  chk("R7 bit7 during pulse", d, 16'h0080);
    repeat (COL + 4) @(negedge clk);
    chk("R7 pulse length", col_seen, COL);
    rd(5'd0, d);  chk("R7 bit7 after pulse", d, 16'h0000);

    // R12 link latch low
    link_up = 1'b0;
    repeat (3) @(negedge clk);
    link_up = 1'b1;
    repeat (2) @(negedge clk);
    rd(5'd1, d);  chk("R12 link held low", d[2], 1'b0);
    rd(5'd1, d);  chk("R12 link live after read", d[2], 1'b1);

    // R13 jabber and remote fault latch high
    @(negedge clk); jabber_det = 1'b1;
    @(negedge clk); jabber_det = 1'b0;
    rd(5'd1, d);  chk("R13 jabber held", d[1], 1'b1);
    rd(5'd1, d);  chk("R13 jabber released", d[1], 1'b0);
    @(negedge clk); remote_fault = 1'b1;
    @(negedge clk); remote_fault = 1'b0;
    rd(5'd1, d);  chk("R13 remote fault held", d[4], 1'b1);
    rd(5'd1, d);  chk("R13 remote fault released", d[4], 1'b0);

    // R2 / R3 soft reset and write blocking
    wr(5'd0, 16'h0100);
    @(negedge clk); jabber_det = 1'b1;
    @(negedge clk); jabber_det = 1'b0;
    busy_seen = 0;
    wr(5'd0, 16'hC000);
    chk("R2 busy raised", reset_busy, 1'b1);
    rd(5'd0, d);  chk("R2 bit15 during reset", d, 16'h9000);
    wr(5'd0, 16'h4100);
    chk("R3 loopback unchanged", loopback_en, 1'b0);
    rd(5'd0, d);  chk("R3 write discarded", d, 16'h9000);
    repeat (RST + 4) @(negedge clk);
    chk("R2 busy length", busy_seen, RST);
    rd(5'd0, d);  chk("R2 control default after reset", d, 16'h1000);
    rd(5'd1, d);  chk("R2 held jabber released", d[1], 1'b0);
    wr(5'd0, 16'h0100);
    rd(5'd0, d);  chk("R3 writes accepted after reset", d, 16'h0100);

    summary();
  end
endmodule